// File: doc/BRIEF.md
# Edge-Compare PWM Timer

This block is a 16-bit timer that places output edges by comparison. A signed counter runs upward from a programmable start value to a programmable end value. The cycle after it reaches or passes the end value, it starts again from the start value. Six compare registers are each checked against the counter. They are grouped into three output channels, and each channel has one set compare and one clear compare. A set match drives the channel's flip-flop high. A clear match drives it low. When both match in the same cycle, the output goes low. Channel 2 is the auxiliary output: its pair doubles as the duty control of the local period-sync signal.

Each compare value is written into a shadow copy first. The shadow copies move into the active compare registers together, but only at a counter restart after software has armed a load request. This keeps a period from being split between old and new values. A compare value that the counter never reaches never matches. Parking one register of a pair that way gives a single set or a single clear that is never undone. Every match raises a sticky flag for that compare and a one-cycle trigger pulse. A per-compare enable mask merges the flags into one interrupt line.

Top module: `edge_pwm_sub`

## Requirements
- R1: The counter, read as a signed 16-bit value, steps by one each cycle. In the cycle after it is greater than or equal to the end value (address 1), it takes the start value (address 0). The period is therefore end minus start plus one cycles.
- R2: In the cycle after the counter equals the active set compare of channel c (compare index 2c), pwm_out[c] is 1, unless R4 applies.
- R3: In the cycle after the counter equals the active clear compare of channel c (compare index 2c+1), pwm_out[c] is 0.
- R4: When the set and clear compares of a channel match in the same cycle, the output is 0 in the next cycle.
- R5: A compare value outside the start-to-end range never matches. With the clear compare parked this way, the output stays high indefinitely, and the parked compare produces no trigger.
- R6: Writes to the shadow compare values (address 2+k for compare k) are ignored by the active compares until a 1 is written to bit 0 of address 8 and a counter restart follows. At that restart all six active compares load and the load request clears, so later shadow writes wait for a new request.
- R7: cmp_flag[k] sets on a match of compare k and stays set until a write to address 10 with bit k at 1. Bits written as 0 leave their flags unchanged.
- R8: irq is 1 exactly when some cmp_flag bit is 1 and the matching bit of the enable mask (address 9, bit k for compare k) is 1.
- R9: cmp_trig[k] is high for one cycle per match of compare k, in the same cycle that the output responds.
- R10: Negative start values work: with start -2 and end 5, every compare value from -2 to 5 is reached once per 8-cycle period.
- R11: After reset, all outputs are 0. The active compares are parked at the most negative value, the start value is 0 and the end value is 32767, so no flag sets until software programs the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address: 0 start, 1 end, 2..7 shadow compares, 8 load request, 9 enable mask, 10 flag clear |
| wr_data | input | 16 | Write data |
| pwm_out | output | 3 | Channel outputs; bit 2 is the auxiliary output |
| cmp_flag | output | 6 | Sticky per-compare match flags |
| cmp_trig | output | 6 | One-cycle per-compare trigger pulses |
| irq | output | 1 | OR of the enabled flags |

## Verification
The hardest case to reach is an exact tie, where the set and clear compares of one channel hit on the same count. It also has to be reached after a load, with no leftover state from earlier settings. The bench sweeps every ordered pair of set and clear positions across a short signed period from -2 to 5. The 8 tie cases fall out of this full sweep. Each pair is loaded through the shadow registers and a load request, and the bench lets the timer settle for several periods. It then counts high cycles and trigger pulses over one period and compares them with the arithmetic expectation.

// File: rtl/edge_pwm_pkg.sv
package edge_pwm_pkg;
  localparam int CW     = 16;
  localparam int NCH    = 3;
  localparam int AW     = 4;
  localparam int A_INIT = 0;
  localparam int A_MOD  = 1;
  localparam int A_EDGE = 2;
  localparam int A_CTRL = 8;
  localparam int A_IEN  = 9;
  localparam int A_FCLR = 10;
endpackage

// File: rtl/edge_pwm_counter.sv
module edge_pwm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] init_v,
  input  logic [W-1:0] mod_v,
  output logic [W-1:0] cnt,
  output logic         reload
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    reload = ($signed(cnt_q) >= $signed(mod_v));
    cnt_d  = reload ? init_v : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/edge_pwm_regs.sv
module edge_pwm_regs
  import edge_pwm_pkg::*;
#(
  parameter int W    = CW,
  parameter int N    = 2 * NCH,
  parameter int AWID = AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AWID-1:0]     wr_addr,
  input  logic [W-1:0]        wr_data,
  input  logic                reload,
  output logic [W-1:0]        init_v,
  output logic [W-1:0]        mod_v,
  output logic [N-1:0][W-1:0] act,
  output logic [N-1:0]        ien,
  output logic [N-1:0]        fclr,
  output logic                ldok
);
  localparam logic [W-1:0] PARK    = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOD_RST = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0]        init_q, init_d, mod_q, mod_d;
  logic [N-1:0][W-1:0] shd_q, shd_d, act_q, act_d;
  logic [N-1:0]        ien_q, ien_d;
  logic                ldok_q, ldok_d;

  always_comb begin
    init_d = init_q;
    mod_d  = mod_q;
    shd_d  = shd_q;
    act_d  = act_q;
    ien_d  = ien_q;
    ldok_d = ldok_q;
    fclr   = '0;
    if (reload && ldok_q) begin
      act_d  = shd_q;
      ldok_d = 1'b0;
    end
    if (wr_en) begin
      if (wr_addr == AWID'(A_INIT)) init_d = wr_data;
      if (wr_addr == AWID'(A_MOD))  mod_d  = wr_data;
      for (int k = 0; k < N; k++)
        if (wr_addr == AWID'(A_EDGE + k)) shd_d[k] = wr_data;
      if (wr_addr == AWID'(A_CTRL) && wr_data[0]) ldok_d = 1'b1;
      if (wr_addr == AWID'(A_IEN))  ien_d = wr_data[N-1:0];
      if (wr_addr == AWID'(A_FCLR)) fclr  = wr_data[N-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= '0;
      mod_q  <= MOD_RST;
      shd_q  <= {N{PARK}};
      act_q  <= {N{PARK}};
      ien_q  <= '0;
      ldok_q <= 1'b0;
    end else begin
      init_q <= init_d;
      mod_q  <= mod_d;
      shd_q  <= shd_d;
      act_q  <= act_d;
      ien_q  <= ien_d;
      ldok_q <= ldok_d;
    end
  end

  assign init_v = init_q;
  assign mod_v  = mod_q;
  assign act    = act_q;
  assign ien    = ien_q;
  assign ldok   = ldok_q;
endmodule

// File: rtl/edge_pwm_chan.sv
module edge_pwm_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic set_hit,
  input  logic clr_hit,
  output logic q
);
  logic q_q, q_d;

  always_comb begin
    if (clr_hit)      q_d = 1'b0;
    else if (set_hit) q_d = 1'b1;
    else              q_d = q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/edge_pwm_sub.sv
module edge_pwm_sub
  import edge_pwm_pkg::*;
#(
  parameter int W    = CW,
  parameter int NC   = NCH,
  parameter int AWID = AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AWID-1:0] wr_addr,
  input  logic [W-1:0]    wr_data,
  output logic [NC-1:0]   pwm_out,
  output logic [2*NC-1:0] cmp_flag,
  output logic [2*NC-1:0] cmp_trig,
  output logic            irq
);
  localparam int NCMP = 2 * NC;

  logic [1:0]             rst_sync;
  logic                   rst_s;
  logic [W-1:0]           cnt, init_v, mod_v;
  logic                   reload, ldok;
  logic [NCMP-1:0][W-1:0] act;
  logic [NCMP-1:0]        ien, fclr, hit;
  logic [NCMP-1:0]        flag_q, flag_d, trig_q, trig_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  edge_pwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_s), .init_v(init_v), .mod_v(mod_v),
    .cnt(cnt), .reload(reload)
  );

  edge_pwm_regs #(.W(W), .N(NCMP), .AWID(AWID)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .reload(reload), .init_v(init_v), .mod_v(mod_v),
    .act(act), .ien(ien), .fclr(fclr), .ldok(ldok)
  );

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    assign hit[k] = (cnt == act[k]);
  end

  for (genvar c = 0; c < NC; c++) begin : g_ch
    edge_pwm_chan u_ch (
      .clk(clk), .rst_n(rst_s),
      .set_hit(hit[2*c]), .clr_hit(hit[2*c+1]),
      .q(pwm_out[c])
    );
  end

  always_comb begin
    flag_d = (flag_q & ~fclr) | hit;
    trig_d = hit;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      flag_q <= '0;
      trig_q <= '0;
    end else begin
      flag_q <= flag_d;
      trig_q <= trig_d;
    end
  end

  assign cmp_flag = flag_q;
  assign cmp_trig = trig_q;
  assign irq      = |(flag_q & ien);
endmodule

// File: rtl/edge_pwm_chk.sv
module edge_pwm_chk
  import edge_pwm_pkg::*;
#(
  parameter int W    = CW,
  parameter int NC   = NCH,
  parameter int AWID = AW
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [AWID-1:0]       wr_addr,
  input logic [W-1:0]          wr_data,
  input logic [W-1:0]          cnt,
  input logic [W-1:0]          init_v,
  input logic                  reload,
  input logic                  ldok,
  input logic [2*NC-1:0][W-1:0] act,
  input logic [2*NC-1:0]       hit,
  input logic [2*NC-1:0]       fclr,
  input logic [NC-1:0]         pwm_out,
  input logic [2*NC-1:0]       cmp_flag,
  input logic [2*NC-1:0]       cmp_trig
);
  logic ctrl_set;
  assign ctrl_set = wr_en && (wr_addr == AWID'(A_CTRL)) && wr_data[0];

  AST_RELOAD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> cnt == $past(init_v)); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> cnt == $past(cnt) + W'(1)); // R1
  AST_LDOK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ldok && reload && !ctrl_set) |=> !ldok); // R6

  for (genvar c = 0; c < NC; c++) begin : g_ch
    AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[2*c] && !hit[2*c+1]) |=> pwm_out[c]); // R2
    AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      hit[2*c+1] |=> !pwm_out[c]); // R3
    AST_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[2*c] && hit[2*c+1]) |=> !pwm_out[c]); // R4
  end

  for (genvar k = 0; k < 2*NC; k++) begin : g_cmp
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_flag[k] && !fclr[k]) |=> cmp_flag[k]); // R7
    AST_TRIG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_trig[k] |-> cmp_flag[k]); // R9
    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(ldok && reload) |=> $stable(act[k])); // R6
  end
endmodule

bind edge_pwm_sub edge_pwm_chk #(.W(W), .NC(NC), .AWID(AWID)) u_chk (
  .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .cnt(cnt), .init_v(init_v), .reload(reload),
  .ldok(ldok), .act(act), .hit(hit), .fclr(fclr), .pwm_out(pwm_out),
  .cmp_flag(cmp_flag), .cmp_trig(cmp_trig)
);

// File: tb/edge_pwm_sub_test.sv
module edge_pwm_sub_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  pwm_out;
  logic [5:0]  cmp_flag, cmp_trig;
  logic        irq;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  localparam int I0 = -2;
  localparam int M0 = 5;
  localparam int P0 = M0 - I0 + 1;

  edge_pwm_sub uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .cmp_flag(cmp_flag),
    .cmp_trig(cmp_trig), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 4'(addr);
    wr_data = 16'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input int ch, input int trg, input int n, output int hi, output int tc);
    hi = 0;
    tc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
      if (cmp_trig[trg]) tc++;
    end
  endtask

  task automatic period(input int trg, output int n);
    n = 0;
    while (!cmp_trig[trg]) @(negedge clk);
    @(negedge clk);
    n = 1;
    while (!cmp_trig[trg] && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        check(1'b0, "watchdog", cyc, 200000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int hi, tc, exp, n;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    idle(4);
    // R11: reset state
    check(pwm_out == 3'b000, "R11 pwm", int'(pwm_out), 0);
    check(cmp_flag == 6'b0 && cmp_trig == 6'b0, "R11 flags", int'(cmp_flag), 0);
    check(irq == 1'b0, "R11 irq", int'(irq), 0);
    rst_n = 1'b1;
    idle(30);
    check(cmp_flag == 6'b0, "R11 parked compares idle", int'(cmp_flag), 0);

    wr(0, I0);
    wr(1, M0);
    // R2 R3 R4 R9 R10: sweep every set/clear pair over a signed period
    for (int s = I0; s <= M0; s++) begin
      for (int r = I0; r <= M0; r++) begin
        wr(2, s);
        wr(3, r);
        wr(8, 1);
        idle(3 * P0);
        measure(0, 0, P0, hi, tc);
        if (s < r)      exp = r - s;
        else if (s > r) exp = P0 - (s - r);
        else            exp = 0;
        if (s == r)
          check(hi == exp, "R4 tie high count", hi, exp);
        else if (s < 0 || r < 0)
          check(hi == exp, "R2/R3/R10 high count", hi, exp);
        else
          check(hi == exp, "R2/R3 high count", hi, exp);
        check(tc == 1, "R9 trigger per period", tc, 1);
      end
    end

    // R5: clear parked beyond range -> stays high, no clear trigger
    wr(4, 3);
    wr(5, 100);
    wr(8, 1);
    idle(3 * P0);
    measure(1, 3, 2 * P0, hi, tc);
    check(hi == 2 * P0, "R5 one-shot high", hi, 2 * P0);
    check(tc == 0, "R5 parked no trigger", tc, 0);
    wr(4, -50);
    wr(5, 2);
    wr(8, 1);
    idle(3 * P0);
    measure(1, 2, 2 * P0, hi, tc);
    check(hi == 0, "R5 one-shot low", hi, 0);
    check(tc == 0, "R5 parked set no trigger", tc, 0);

    // R6: buffering on the auxiliary channel
    wr(6, 0);
    wr(7, 4);
    wr(8, 1);
    idle(3 * P0);
    measure(2, 4, P0, hi, tc);
    check(hi == 4, "R6 loaded value", hi, 4);
    wr(6, 1);
    idle(3 * P0);
    measure(2, 4, P0, hi, tc);
    check(hi == 4, "R6 shadow write ignored", hi, 4);
    wr(8, 1);
    idle(3 * P0);
    measure(2, 4, P0, hi, tc);
    check(hi == 3, "R6 load after request", hi, 3);

    // R1: period from trigger spacing
    period(4, n);
    check(n == P0, "R1 period", n, P0);
    wr(1, 9);
    idle(3 * 12);
    period(4, n);
    check(n == 12, "R1 period after end change", n, 12);
    wr(1, M0);
    idle(3 * P0);

    // R7 R8: sticky flags, clear, interrupt mask
    check(cmp_flag[0] == 1'b1, "R7 flag set", int'(cmp_flag[0]), 1);
    wr(9, 0);
    check(irq == 1'b0, "R8 masked", int'(irq), 0);
    wr(9, 1);
    check(irq == 1'b1, "R8 enabled", int'(irq), 1);
    wr(2, 100);
    wr(3, 100);
    wr(8, 1);
    idle(3 * P0);
    check(cmp_flag[0] == 1'b1, "R7 sticky after matches stop", int'(cmp_flag[0]), 1);
    wr(10, 1);
    check(cmp_flag[0] == 1'b0, "R7 cleared", int'(cmp_flag[0]), 0);
    check(cmp_flag[4] == 1'b1, "R7 other flag kept", int'(cmp_flag[4]), 1);
    idle(P0);
    check(cmp_flag[0] == 1'b0, "R7 stays clear", int'(cmp_flag[0]), 0);
    check(irq == 1'b0, "R8 after clear", int'(irq), 0);
    wr(9, 16);
    check(irq == 1'b1, "R8 other enable", int'(irq), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule